// File: doc/BRIEF.md
# Mode-Switchable Serial Receive Buffer

This block holds characters that a serial receiver has assembled, until bus software reads them. Each entry is 12 bits wide: an 8-bit character in bits 7:0 and four line-error flags in bits 11:8. The buffer is circular. Its effective depth changes at run time: with the buffered mode selected it holds `DEPTH` entries (16 by default), and with the mode deselected it holds a single entry. The head entry is presented combinationally on the read port, and a read strobe pops it.

The line side pushes characters through a write strobe. It should push only while `can_accept_o` is high; a push into a full buffer is discarded. The block reports full and empty flags and an occupancy count. It also keeps a receive interrupt bit. That bit is set and cleared only on exact count transitions around a trigger level that is fixed at one: it is set when a push makes the count equal the trigger, and cleared when a pop leaves the count one below it. Any change of the mode input, and an explicit flush request, discard all stored entries.

Top module: `uart_rx_fifo`

## Requirements
- R1: The effective depth is `DEPTH` (16) while `fifo_en_i` is 1 and 1 while it is 0, and `count_o` never exceeds the effective depth.
- R2: Entries leave in the order they arrived. Each entry is packed as {`wr_err_i`[3:0], `wr_data_i`[7:0]}, with the error flags in bits 11:8.
- R3: `full_o` is 1 exactly when the count equals the effective depth. `can_accept_o` is 1 exactly when the count is below the effective depth.
- R4: `rd_data_o` always shows the head entry. A read strobe pops one entry when the count is nonzero and leaves the count at zero otherwise.
- R5: `empty_o` is 1 exactly when the count is zero.
- R6: `rx_irq_o` rises on the cycle after an accepted write that brings the count to the trigger level of 1.
- R7: `rx_irq_o` is cleared by a read that leaves the count at 0, including a read of an already empty buffer. A read that leaves a nonzero count does not change it.
- R8: A flush, either `flush_i` or a change of `fifo_en_i`, sets the count to zero and the empty flag in the next cycle. It overrides a write or read in the same cycle and leaves `rx_irq_o` unchanged.
- R9: After a synchronous reset the buffer is empty, the count is zero, `rx_irq_o` is 0 and the single-entry mode is in force.
- R10: A write while the buffer is full and no read is in the same cycle is dropped: the count and the stored contents stay as they were.
- R11: A read and a write in the same cycle act as a pop followed by a push, so in single-entry mode a full buffer takes the new character in place of the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en_i | input | 1 | 1 selects the full depth, 0 selects a single entry; any change flushes |
| flush_i | input | 1 | Discards all entries |
| wr_en_i | input | 1 | Push strobe from the line side |
| wr_data_i | input | 8 | Received character |
| wr_err_i | input | 4 | Error flags for the character |
| rd_en_i | input | 1 | Pop strobe from the bus read |
| rd_data_o | output | 12 | Head entry, {err, data} |
| full_o | output | 1 | Count equals effective depth |
| empty_o | output | 1 | Count is zero |
| count_o | output | $clog2(DEPTH+1) | Occupancy |
| can_accept_o | output | 1 | Room for one more entry |
| rx_irq_o | output | 1 | Receive interrupt level |

## Verification
A corrupted read position shows up at `rd_data_o` in the same cycle as the next pop, because the wrong entry comes out. A miscounted occupancy shows up one cycle after the faulty operation, on `count_o` and the flags, or when the wrong push is dropped or accepted at the depth boundary. Interrupt errors only become visible on the exact transitions to a count of 1 and to a count of 0. The bench therefore drives long random runs in both modes and forces many reads of an empty buffer and pushes into a full one.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;

    typedef struct packed {
        logic [3:0] err;
        logic [7:0] data;
    } rxf_entry_t;

    localparam int unsigned RXF_TRIGGER = 1;

    function automatic int unsigned rxf_depth(input logic buffered, input int unsigned full_depth);
        return buffered ? full_depth : 1;
    endfunction

endpackage

// File: rtl/uart_rx_fifo_store.sv
module uart_rx_fifo_store
    import uart_rx_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       wr_fire,
    input  logic [PW-1:0] wr_slot,
    input  rxf_entry_t wr_entry,
    input  logic [PW-1:0] rd_pos,
    output rxf_entry_t rd_entry
);

    rxf_entry_t mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_fire && wr_slot == PW'(g)) begin
                mem[g] <= wr_entry;
            end
        end
    end

    assign rd_entry = mem[rd_pos];

endmodule

// File: rtl/uart_rx_fifo_ctrl.sv
module uart_rx_fifo_ctrl
    import uart_rx_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en_i,
    input  logic          flush_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    output logic          wr_fire,
    output logic [PW-1:0] wr_slot,
    output logic [PW-1:0] rd_pos,
    output logic          full_o,
    output logic          empty_o,
    output logic [CW-1:0] count_o,
    output logic          can_accept_o,
    output logic          rx_irq_o
);

    logic          mode_q;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [PW-1:0] pos_q, pos_d;
    logic          full_q, full_d, empty_q, empty_d, irq_q, irq_d;
    logic          flush;
    logic [CW-1:0] depth;
    logic [PW-1:0] mask;

    assign depth = CW'(rxf_depth(mode_q, DEPTH));
    assign mask  = PW'(rxf_depth(mode_q, DEPTH) - 1);
    assign flush = flush_i | (fifo_en_i != mode_q);

    always_comb begin
        cnt_d   = cnt_q;
        pos_d   = pos_q;
        full_d  = full_q;
        empty_d = empty_q;
        irq_d   = irq_q;
        wr_fire = 1'b0;
        wr_slot = '0;
        if (flush) begin
            cnt_d   = '0;
            pos_d   = '0;
            full_d  = 1'b0;
            empty_d = 1'b1;
        end else begin
            if (rd_en_i) begin
                full_d = 1'b0;
                if (cnt_d != '0) begin
                    cnt_d = cnt_d - CW'(1);
                    pos_d = (pos_d + PW'(1)) & mask;
                end
                if (cnt_d == '0) empty_d = 1'b1;
                if (cnt_d + CW'(1) == CW'(RXF_TRIGGER)) irq_d = 1'b0;
            end
            if (wr_en_i && cnt_d < depth) begin
                wr_fire = 1'b1;
                wr_slot = (pos_d + cnt_d[PW-1:0]) & mask;
                cnt_d   = cnt_d + CW'(1);
                empty_d = 1'b0;
                if (cnt_d == depth) full_d = 1'b1;
                if (cnt_d == CW'(RXF_TRIGGER)) irq_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            cnt_q   <= '0;
            pos_q   <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
            irq_q   <= 1'b0;
        end else begin
            mode_q  <= fifo_en_i;
            cnt_q   <= cnt_d;
            pos_q   <= pos_d;
            full_q  <= full_d;
            empty_q <= empty_d;
            irq_q   <= irq_d;
        end
    end

    assign rd_pos       = pos_q;
    assign full_o       = full_q;
    assign empty_o      = empty_q;
    assign count_o      = cnt_q;
    assign can_accept_o = cnt_q < depth;
    assign rx_irq_o     = irq_q;

    // R1: occupancy bounded by the effective depth
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= depth);
    // R3: full flag tracks the count
    p_full_match_r3: assert property (@(posedge clk) disable iff (rst)
        full_q == (cnt_q == depth));
    // R5: empty flag tracks the count
    p_empty_match_r5: assert property (@(posedge clk) disable iff (rst)
        empty_q == (cnt_q == '0));
    // R6: push onto an empty buffer raises the interrupt
    p_irq_set_r6: assert property (@(posedge clk) disable iff (rst)
        (!flush && wr_en_i && !rd_en_i && cnt_q == CW'(RXF_TRIGGER - 1)) |=> irq_q);
    // R8: flush empties the buffer
    p_flush_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt_q == '0 && empty_q));
    // R8: flush leaves the interrupt bit alone
    p_flush_irq_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> $stable(irq_q));
    // R10: push into a full buffer is dropped
    p_drop_full_r10: assert property (@(posedge clk) disable iff (rst)
        (!flush && wr_en_i && !rd_en_i && cnt_q == depth) |=> $stable(cnt_q));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en_i,
    input  logic          flush_i,
    input  logic          wr_en_i,
    input  logic [7:0]    wr_data_i,
    input  logic [3:0]    wr_err_i,
    input  logic          rd_en_i,
    output logic [11:0]   rd_data_o,
    output logic          full_o,
    output logic          empty_o,
    output logic [CW-1:0] count_o,
    output logic          can_accept_o,
    output logic          rx_irq_o
);

    logic          wr_fire;
    logic [PW-1:0] wr_slot, rd_pos;
    rxf_entry_t    wr_entry, rd_entry;

    assign wr_entry = '{err: wr_err_i, data: wr_data_i};

    uart_rx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .fifo_en_i(fifo_en_i), .flush_i(flush_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wr_fire(wr_fire),
        .wr_slot(wr_slot), .rd_pos(rd_pos), .full_o(full_o), .empty_o(empty_o),
        .count_o(count_o), .can_accept_o(can_accept_o), .rx_irq_o(rx_irq_o)
    );

    uart_rx_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .wr_fire(wr_fire), .wr_slot(wr_slot), .wr_entry(wr_entry),
        .rd_pos(rd_pos), .rd_entry(rd_entry)
    );

    assign rd_data_o = rd_entry;

endmodule

// File: tb/uart_rx_fifo_tb.sv
module uart_rx_fifo_tb;

    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic fifo_en = 1'b0, flush = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [3:0] werr = '0;
    logic [11:0] rdata;
    logic full, empty, can_acc, irq;
    logic [CW-1:0] count;

    int n_chk = 0, n_fail = 0;
    logic [11:0] q [$];
    logic mode_m = 1'b0, irq_m = 1'b0;

    always #2 clk = ~clk;

    uart_rx_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .fifo_en_i(fifo_en), .flush_i(flush),
        .wr_en_i(wr), .wr_data_i(wdata), .wr_err_i(werr), .rd_en_i(rd),
        .rd_data_o(rdata), .full_o(full), .empty_o(empty), .count_o(count),
        .can_accept_o(can_acc), .rx_irq_o(irq)
    );

    function automatic int depth_m();
        return mode_m ? DEPTH : 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state();
        check("R1 count", int'(count), q.size());
        check("R3 full", int'(full), int'(q.size() == depth_m()));
        check("R3 can_accept", int'(can_acc), int'(q.size() < depth_m()));
        check("R5 empty", int'(empty), int'(q.size() == 0));
        check("R6/R7 irq", int'(irq), int'(irq_m));
    endtask

    // one cycle: inputs set after negedge, head checked, then model advanced at posedge
    task automatic step(input logic en, input logic fl, input logic w, input logic r,
                        input logic [11:0] ent);
        fifo_en = en; flush = fl; wr = w; rd = r;
        wdata = ent[7:0]; werr = ent[11:8];
        #1;
        if (r && q.size() > 0) check("R2/R4 head data", int'(rdata), int'(q[0]));
        @(posedge clk);
        if (fl || en != mode_m) begin
            q.delete();
        end else begin
            if (r) begin
                if (q.size() > 0) void'(q.pop_front());
                if (q.size() == 0) irq_m = 1'b0;
            end
            if (w && q.size() < depth_m()) begin
                q.push_back(ent);
                if (q.size() == 1) irq_m = 1'b1;
            end
        end
        mode_m = en;
        @(negedge clk);
        check_state();
    endtask

    initial begin : watchdog
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state(); // R9 reset state
        check("R9 single-entry after reset", int'(can_acc), 1);

        // R1/R10 single-entry mode: second write dropped
        step(1'b0, 1'b0, 1'b1, 1'b0, 12'h3A5);
        step(1'b0, 1'b0, 1'b1, 1'b0, 12'h0FF);
        check("R10 dropped count", int'(count), 1);
        // R11 read+write while full in single-entry mode
        step(1'b0, 1'b0, 1'b1, 1'b1, 12'h812);
        step(1'b0, 1'b0, 1'b0, 1'b1, 12'h0);
        check("R7 irq cleared on last pop", int'(irq), 0);
        // R7 read of empty buffer
        step(1'b0, 1'b0, 1'b0, 1'b1, 12'h0);

        // mode change to buffered: flush (R8), then fill to full
        step(1'b1, 1'b0, 1'b1, 1'b0, 12'h111);
        for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 12'(i * 37 + 5));
        check("R3 full at depth", int'(full), 1);
        // R8 flush with write same cycle; irq kept
        step(1'b1, 1'b1, 1'b1, 1'b0, 12'hABC);
        check("R8 irq kept through flush", int'(irq), 1);
        // R6 set from empty
        step(1'b1, 1'b0, 1'b1, 1'b0, 12'h777);
        step(1'b1, 1'b0, 1'b1, 1'b0, 12'h778);
        step(1'b1, 1'b0, 1'b0, 1'b1, 12'h0);
        check("R7 irq holds on nonzero pop", int'(irq), 1);
        // mode change back with entries
        step(1'b0, 1'b0, 1'b0, 1'b0, 12'h0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(99);
            logic en_r = (i / 500) % 2 == 1 ? 1'b1 : 1'b0;
            if (r < 2) en_r = ~en_r;
            step(en_r, $urandom_range(99) < 3, $urandom_range(99) < 55,
                 $urandom_range(99) < 45, 12'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule